// File: doc/BRIEF.md
# Filtered Branch History Ring Recorder

This block keeps a short running history of taken branches for a performance-monitoring unit. Each clock cycle it can accept one taken-branch event. An event carries the address of the branch instruction, its destination address, a one-hot type vector and the privilege state of the processor (user/problem state and hypervisor). The block decides whether the event is recorded and, if so, writes it into a ring of 64-bit entries. The write pointer wraps, so the newest records overwrite the oldest.

Two things gate recording. The first is a type filter. It is captured from monitor control fields only when those fields are written, and it selects which branch types are accepted. The second is a set of privilege-dependent freeze rules, plus an optional stricter gate for the newer architecture mode, which are evaluated live. A branch whose destination comes from a register produces two records: the instruction address, then the destination address tagged with a marker bit. Software-side logic reads entries through a combinational index port. The current write pointer is visible so that the age of each entry can be worked out.

Top module: `branch_ring_recorder`

## Requirements
- R1: After reset the write pointer is 0, every entry reads 0, and the filter rejects every event until the control fields are first written.
- R2: Each stored record advances the write pointer by one. The pointer wraps modulo the depth (32 entries by default, with log2 depth clamped to at most 5), so the oldest entries are overwritten. Without an event the pointer holds.
- R3: The type bits are: bit 0 call, bit 1 indirect, bit 2 conditional, bit 3 other, bit 4 register-target. An event whose type is 0 is never recorded, and a type with only bit 4 set is recorded in mode 0.
- R4: Filter mode 0 accepts any nonzero type, mode 1 accepts only types with the call bit, mode 2 only those with the indirect bit, and mode 3 only those with the conditional bit.
- R5: The filter is loaded only in a cycle where `ctrlWrite` is 1. If `alertEnable` is 0 in that write, the loaded filter rejects everything. An event in the same cycle as a write uses the previous filter.
- R6: A recorded event with type bit 4 set writes two entries in one cycle. The first is the instruction address and the second, in the next slot, is the destination address with bit 1 set. The pointer advances by two.
- R7: With `freezeSelect`=1 and `freezeUser`=1, recording is suppressed when hypervisor and problem state are both 1. With `freezeSelect`=1 and `freezeUser`=0, it is suppressed when hypervisor is 0 and problem state is 1. With `freezeSelect`=0, it is suppressed when `freezeUser`=1 and problem state is 1.
- R8: When the NEWER_ARCH parameter is set (the default), recording is also suppressed while `recordDisable` is 1 or problem state is 0.
- R9: The stored instruction-address entry has its low two bits forced to 0.
- R10: `rdData` shows the entry at `rdIndex` combinationally. A read of the slot being written in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evtValid | input | 1 | A taken-branch event is present this cycle |
| evtInstAddr | input | 64 | Address of the branch instruction |
| evtTargetAddr | input | 64 | Destination address of the branch |
| evtType | input | 5 | One-hot type bits plus the register-target flag (bit 4) |
| evtProblem | input | 1 | Processor is in problem (user) state |
| evtHyper | input | 1 | Processor is in hypervisor state |
| ctrlWrite | input | 1 | Control fields are being written this cycle |
| alertEnable | input | 1 | Monitor alert enable, captured on ctrlWrite |
| filterMode | input | 2 | Type filter mode, captured on ctrlWrite |
| recordDisable | input | 1 | Recording disable (newer mode only) |
| freezeSelect | input | 1 | Selects which freeze rule applies |
| freezeUser | input | 1 | Freeze qualifier for problem state |
| rdIndex | input | 5 | Entry index to read |
| rdData | output | 64 | Entry contents at rdIndex |
| wrPtr | output | 5 | Slot the next record will be written to |

## Verification
An event or control write presented before a rising edge shows up in `wrPtr` and in the ring entries right after that edge. There is exactly one register stage and the read path is combinational. The bench drives inputs at the falling edge and reads the slot about to be written just before the rising edge, which must still hold the old value. It then samples the pointer and the newest and one random entry 1 ns after the rising edge, against a model updated for that same edge. A control write therefore affects only events from the next cycle on, and the model applies it after evaluating the current event.

// File: rtl/brh_pkg.sv
package brh_pkg;
  localparam int MAX_LOG2 = 5;
  localparam int SLOT_W = MAX_LOG2;

  localparam int TB_CALL = 0;
  localparam int TB_IND = 1;
  localparam int TB_COND = 2;
  localparam int TB_OTHER = 3;
  localparam int TB_REGTGT = 4;
  localparam int TYPE_W = 5;

  typedef struct packed {
    logic wrFirst;
    logic wrSecond;
    logic [SLOT_W-1:0] slotFirst;
    logic [SLOT_W-1:0] slotSecond;
  } brhStrobe_t;

  function automatic logic [TYPE_W-1:0] modeMask(input logic enable, input logic [1:0] mode);
    logic [TYPE_W-1:0] m;
    if (!enable) m = '0;
    else begin
      unique case (mode)
        2'd0: m = '1;
        2'd1: m = TYPE_W'(1) << TB_CALL;
        2'd2: m = TYPE_W'(1) << TB_IND;
        default: m = TYPE_W'(1) << TB_COND;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/brh_ctrl.sv
module brh_ctrl
  import brh_pkg::*;
#(
  parameter int DEPTH_LOG2 = 5,
  parameter bit NEWER_ARCH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evtValid,
  input  logic [TYPE_W-1:0] evtType,
  input  logic evtProblem,
  input  logic evtHyper,
  input  logic ctrlWrite,
  input  logic alertEnable,
  input  logic [1:0] filterMode,
  input  logic recordDisable,
  input  logic freezeSelect,
  input  logic freezeUser,
  output brhStrobe_t strobe,
  output logic [SLOT_W-1:0] wrPtr
);
  localparam int EFF_LOG2 = (DEPTH_LOG2 > MAX_LOG2) ? MAX_LOG2 : DEPTH_LOG2;
  localparam logic [SLOT_W-1:0] PTR_MASK = SLOT_W'((1 << EFF_LOG2) - 1);

  logic [TYPE_W-1:0] filterMask;
  logic [SLOT_W-1:0] ptrQ;
  logic frozen, archBlock, typeHit, take, twoEntries;

  always_comb begin
    if (freezeSelect) frozen = freezeUser ? (evtHyper && evtProblem) : (!evtHyper && evtProblem);
    else frozen = freezeUser && evtProblem;
  end

  assign archBlock = NEWER_ARCH && (recordDisable || !evtProblem);
  assign typeHit = |(evtType & filterMask);
  assign take = evtValid && typeHit && !frozen && !archBlock;
  assign twoEntries = evtType[TB_REGTGT];

  always_comb begin
    strobe.wrFirst = take;
    strobe.wrSecond = take && twoEntries;
    strobe.slotFirst = ptrQ;
    strobe.slotSecond = (ptrQ + SLOT_W'(1)) & PTR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filterMask <= '0;
      ptrQ <= '0;
    end else begin
      if (ctrlWrite) filterMask <= modeMask(alertEnable, filterMode);
      if (take) ptrQ <= (ptrQ + (twoEntries ? SLOT_W'(2) : SLOT_W'(1))) & PTR_MASK;
    end
  end

  assign wrPtr = ptrQ;
endmodule

// File: rtl/brh_store.sv
module brh_store
  import brh_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int DEPTH_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  brhStrobe_t strobe,
  input  logic [ENTRY_W-1:0] instAddr,
  input  logic [ENTRY_W-1:0] targetAddr,
  input  logic [SLOT_W-1:0] rdIndex,
  output logic [ENTRY_W-1:0] rdData
);
  localparam int EFF_LOG2 = (DEPTH_LOG2 > MAX_LOG2) ? MAX_LOG2 : DEPTH_LOG2;
  localparam int DEPTH = 1 << EFF_LOG2;
  localparam int IDX_W = (EFF_LOG2 < 1) ? 1 : EFF_LOG2;

  logic [ENTRY_W-1:0] ring [DEPTH];
  logic [ENTRY_W-1:0] firstWord, secondWord;

  assign firstWord = {instAddr[ENTRY_W-1:2], 2'b00};
  assign secondWord = targetAddr | ENTRY_W'(2);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hitFirst, hitSecond;
    assign hitFirst = strobe.wrFirst && (strobe.slotFirst[IDX_W-1:0] == IDX_W'(g));
    assign hitSecond = strobe.wrSecond && (strobe.slotSecond[IDX_W-1:0] == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ring[g] <= '0;
      else if (hitFirst) ring[g] <= firstWord;
      else if (hitSecond) ring[g] <= secondWord;
    end
  end

  assign rdData = ring[rdIndex[IDX_W-1:0]];
endmodule

// File: rtl/branch_ring_recorder.sv
module branch_ring_recorder
  import brh_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int DEPTH_LOG2 = 5,
  parameter bit NEWER_ARCH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evtValid,
  input  logic [63:0] evtInstAddr,
  input  logic [63:0] evtTargetAddr,
  input  logic [4:0] evtType,
  input  logic evtProblem,
  input  logic evtHyper,
  input  logic ctrlWrite,
  input  logic alertEnable,
  input  logic [1:0] filterMode,
  input  logic recordDisable,
  input  logic freezeSelect,
  input  logic freezeUser,
  input  logic [4:0] rdIndex,
  output logic [63:0] rdData,
  output logic [4:0] wrPtr
);
  brhStrobe_t strobe;

  brh_ctrl #(.DEPTH_LOG2(DEPTH_LOG2), .NEWER_ARCH(NEWER_ARCH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtType(evtType),
    .evtProblem(evtProblem), .evtHyper(evtHyper), .ctrlWrite(ctrlWrite),
    .alertEnable(alertEnable), .filterMode(filterMode), .recordDisable(recordDisable),
    .freezeSelect(freezeSelect), .freezeUser(freezeUser), .strobe(strobe), .wrPtr(wrPtr)
  );

  brh_store #(.ENTRY_W(ENTRY_W), .DEPTH_LOG2(DEPTH_LOG2)) store_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .instAddr(evtInstAddr[ENTRY_W-1:0]),
    .targetAddr(evtTargetAddr[ENTRY_W-1:0]), .rdIndex(rdIndex), .rdData(rdData)
  );
endmodule

// File: rtl/brh_checker.sv
module brh_checker #(
  parameter int DEPTH_LOG2 = 5,
  parameter bit NEWER_ARCH = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic evtValid,
  input logic [4:0] evtType,
  input logic evtProblem,
  input logic evtHyper,
  input logic recordDisable,
  input logic freezeSelect,
  input logic freezeUser,
  input logic [4:0] wrPtr
);
  localparam int EFF_LOG2 = (DEPTH_LOG2 > 5) ? 5 : DEPTH_LOG2;
  localparam logic [4:0] MASK = 5'((1 << EFF_LOG2) - 1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evtValid |=> $stable(wrPtr));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && !evtType[4]) |=> ($stable(wrPtr) || wrPtr == (($past(wrPtr) + 5'd1) & MASK)));

  p_type_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtType == 5'd0) |=> $stable(wrPtr));

  p_double_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtType[4]) |=> ($stable(wrPtr) || wrPtr == (($past(wrPtr) + 5'd2) & MASK)));

  p_freeze_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (freezeSelect && freezeUser && evtHyper && evtProblem) |=> $stable(wrPtr));

  p_freeze_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freezeSelect && freezeUser && evtProblem) |=> $stable(wrPtr));

  p_newer_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (NEWER_ARCH && (recordDisable || !evtProblem)) |=> $stable(wrPtr));
endmodule

bind branch_ring_recorder brh_checker #(.DEPTH_LOG2(DEPTH_LOG2), .NEWER_ARCH(NEWER_ARCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtType(evtType),
  .evtProblem(evtProblem), .evtHyper(evtHyper), .recordDisable(recordDisable),
  .freezeSelect(freezeSelect), .freezeUser(freezeUser), .wrPtr(wrPtr)
);

// File: tb/branch_ring_recorder_tb_top.sv
module branch_ring_recorder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtValid = 1'b0;
  logic [63:0] evtInstAddr = '0;
  logic [63:0] evtTargetAddr = '0;
  logic [4:0] evtType = '0;
  logic evtProblem = 1'b1;
  logic evtHyper = 1'b0;
  logic ctrlWrite = 1'b0;
  logic alertEnable = 1'b0;
  logic [1:0] filterMode = '0;
  logic recordDisable = 1'b0;
  logic freezeSelect = 1'b0;
  logic freezeUser = 1'b0;
  logic [4:0] rdIndex = '0;
  logic [63:0] rdData;
  logic [4:0] wrPtr;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [32];
  logic [4:0] mPtr = '0;
  logic [4:0] mFilter = '0;

  always #5 clk = ~clk;

  branch_ring_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtInstAddr(evtInstAddr),
    .evtTargetAddr(evtTargetAddr), .evtType(evtType), .evtProblem(evtProblem),
    .evtHyper(evtHyper), .ctrlWrite(ctrlWrite), .alertEnable(alertEnable),
    .filterMode(filterMode), .recordDisable(recordDisable), .freezeSelect(freezeSelect),
    .freezeUser(freezeUser), .rdIndex(rdIndex), .rdData(rdData), .wrPtr(wrPtr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] expMask(input logic en, input logic [1:0] m);
    if (!en) return 5'h00;
    case (m)
      2'd0: return 5'h1F;
      2'd1: return 5'h01;
      2'd2: return 5'h02;
      default: return 5'h04;
    endcase
  endfunction

  function automatic bit isFrozen(input logic sel, input logic usr, input logic hyp, input logic prob);
    if (sel && usr) return hyp && prob;
    if (sel) return !hyp && prob;
    return usr && prob;
  endfunction

  // One clock: inputs already set at a falling edge
  task automatic cycle(input string req);
    bit take;
    logic [4:0] nextFilter;
    logic [4:0] probe;
    rdIndex = mPtr;
    #1;
    chk("R10", rdData, model[mPtr]);
    take = evtValid && ((evtType & mFilter) != 5'd0) &&
           !isFrozen(freezeSelect, freezeUser, evtHyper, evtProblem) &&
           !(recordDisable || !evtProblem);
    nextFilter = ctrlWrite ? expMask(alertEnable, filterMode) : mFilter;
    @(posedge clk);
    #1;
    if (take) begin
      model[mPtr] = {evtInstAddr[63:2], 2'b00};
      mPtr = mPtr + 5'd1;
      if (evtType[4]) begin
        model[mPtr] = evtTargetAddr | 64'h2;
        mPtr = mPtr + 5'd1;
      end
    end
    mFilter = nextFilter;
    chk(req, {59'd0, wrPtr}, {59'd0, mPtr});
    rdIndex = mPtr - 5'd1;
    #1;
    chk(req, rdData, model[mPtr - 5'd1]);
    probe = 5'($urandom_range(0, 31));
    rdIndex = probe;
    #1;
    chk(req, rdData, model[probe]);
    @(negedge clk);
    evtValid = 1'b0;
    ctrlWrite = 1'b0;
  endtask

  task automatic setCtrl(input logic en, input logic [1:0] m);
    ctrlWrite = 1'b1;
    alertEnable = en;
    filterMode = m;
  endtask

  task automatic event1(input logic [63:0] ia, input logic [63:0] ta, input logic [4:0] ty);
    evtValid = 1'b1;
    evtInstAddr = ia;
    evtTargetAddr = ta;
    evtType = ty;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", {59'd0, wrPtr}, 64'd0);
    for (int i = 0; i < 32; i++) begin
      rdIndex = 5'(i);
      #1;
      chk("R1", rdData, 64'd0);
    end
    @(negedge clk);
    // R1: filter rejects until first write
    event1(64'h1000, 64'h2000, 5'h01);
    cycle("R1");
    // R5: write and event in same cycle uses old filter
    setCtrl(1'b1, 2'd0);
    event1(64'h1100, 64'h2100, 5'h01);
    cycle("R5");
    // R9: low bits cleared
    event1(64'hDEAD_BEEF_0000_1003, 64'h0, 5'h01);
    cycle("R9");
    // R6: register-target pair
    event1(64'h0000_0000_0000_4004, 64'h0000_0000_0000_8000, 5'h12);
    cycle("R6");
    // R3: type 0 never recorded, bit 4 alone accepted in mode 0
    event1(64'h5000, 64'h6000, 5'h00);
    cycle("R3");
    event1(64'h5100, 64'h6100, 5'h10);
    cycle("R3");
    event1(64'h5200, 64'h6200, 5'h08);
    cycle("R3");
    // R4: each mode
    for (int m = 1; m < 4; m++) begin
      setCtrl(1'b1, 2'(m));
      cycle("R4");
      for (int t = 0; t < 4; t++) begin
        event1(64'h7000 + 64'(m * 64 + t * 8), 64'h9000, 5'(1 << t));
        cycle("R4");
      end
    end
    // R5: alert disabled rejects all
    setCtrl(1'b0, 2'd0);
    cycle("R5");
    event1(64'hA000, 64'hB000, 5'h01);
    cycle("R5");
    setCtrl(1'b1, 2'd0);
    cycle("R5");
    // R7: freeze combinations
    for (int c = 0; c < 16; c++) begin
      freezeSelect = c[0];
      freezeUser = c[1];
      evtHyper = c[2];
      evtProblem = 1'b1;
      event1(64'hC000 + 64'(c * 16), 64'hD000, 5'h04);
      cycle("R7");
    end
    freezeSelect = 1'b0; freezeUser = 1'b0; evtHyper = 1'b0;
    // R8: newer-mode gate
    recordDisable = 1'b1;
    event1(64'hE000, 64'hF000, 5'h01);
    cycle("R8");
    recordDisable = 1'b0;
    evtProblem = 1'b0;
    event1(64'hE100, 64'hF100, 5'h01);
    cycle("R8");
    evtProblem = 1'b1;
    // R2: wrap and overwrite
    for (int i = 0; i < 40; i++) begin
      event1(64'h1_0000 + 64'(i * 4), 64'h0, 5'h01);
      cycle("R2");
    end
    // Random mix
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(0, 9) == 0) setCtrl($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)));
      recordDisable = ($urandom_range(0, 7) == 0);
      evtProblem = ($urandom_range(0, 5) != 0);
      evtHyper = 1'($urandom_range(0, 1));
      freezeSelect = ($urandom_range(0, 3) == 0);
      freezeUser = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 3) != 0)
        event1({$urandom, $urandom}, {$urandom, $urandom},
               ($urandom_range(0, 15) == 0) ? 5'h00 :
               (5'(1 << $urandom_range(0, 3)) | (($urandom_range(0, 2) == 0) ? 5'h10 : 5'h00)));
      cycle("R4");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule